// File: doc/BRIEF.md
# Coded Post-Divider With Glitchless Enable

This block takes a fast source clock and produces a slower clock from it. The ratio is chosen by a 2-bit code: divide by 1, 2, 4 or 8. The code-to-ratio mapping is not binary. The result leaves on a true and complementary pair. Every ratio keeps a 50% duty cycle. A test tap gives the output divided by four again, for diagnostic paths.

An output enable lets software or board logic stop the clock without producing runt pulses. The enable and the ratio code are both taken only at period boundaries, at the falling source edge that closes a low phase. A disable therefore lets the running period finish and then parks the output low, with the complement high. An enable always starts with a full high phase. The divide-by-1 path sends the source clock itself through an AND gate. That gate is steered from the falling-edge domain, so it can only open or close while the source clock is low.

Top module: `coded_post_divider`

## Requirements
- R1: The ratio code maps as 2'b00 to divide by 2, 2'b01 to divide by 4, 2'b10 to divide by 8 and 2'b11 to divide by 1. Every output period starts with a rising edge aligned to a rising source edge.
- R2: For ratio R of 2, 4 or 8, the output is high for R/2 whole source cycles and then low for R/2 whole source cycles.
- R3: While the output is disabled, the true output is low and the complementary output is high.
- R4: The enable is sampled only at the falling source edge that ends a period, or on every falling edge while the output is parked. A disable lets the current period complete. An enable starts a period with a full high phase. Enable pulses between boundaries have no effect.
- R5: A new ratio code is taken only at a period boundary, under the same sampling rule as R4, so no shortened or stretched period appears.
- R6: The test tap starts low after reset and toggles at every second rising edge of the output, which makes it the output divided by 4.
- R7: In divide-by-1 mode the output is high in the high half of each source cycle and low in the low half. The gate only changes while the source clock is low.
- R8: The complementary output is always the inverse of the true output.
- R9: Reset parks both outputs (true low, complement high) and clears the tap. The first period after reset uses the code and enable sampled at the first falling source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Ratio code, see R1 |
| out_en | input | 1 | Output enable, active high |
| clk_out | output | 1 | Divided clock, true phase |
| clk_out_n | output | 1 | Divided clock, complementary phase |
| test_div4 | output | 1 | Output divided by four, for test |

## Verification
A bad period index or a bad held ratio code shows at the outputs within one output period. It appears as a high or low phase of the wrong length, or as a rising edge at the wrong source cycle. A wrong enable register shows as an aborted period or a pulse shorter than a full high phase. A fault in the divide-by-1 gate shows as a level in the low half of a source cycle. The reference model samples both halves of every source cycle, so each of these faults is caught in the half-cycle where it first appears. A miscounted tap is caught at the next output rising edge.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned MAX_RATIO = 8;
  localparam int unsigned IDX_W     = $clog2(MAX_RATIO);

  typedef enum logic [CODE_W-1:0] {
    RC_DIV2 = 2'b00,
    RC_DIV4 = 2'b01,
    RC_DIV8 = 2'b10,
    RC_DIV1 = 2'b11
  } ratio_code_e;

  // index of the final source cycle of one output period
  function automatic logic [IDX_W-1:0] last_idx(ratio_code_e c);
    case (c)
      RC_DIV2: return IDX_W'(1);
      RC_DIV4: return IDX_W'(3);
      RC_DIV8: return IDX_W'(7);
      default: return IDX_W'(0);
    endcase
  endfunction

  // number of source cycles spent high in one period
  function automatic logic [IDX_W-1:0] high_len(ratio_code_e c);
    case (c)
      RC_DIV2: return IDX_W'(1);
      RC_DIV4: return IDX_W'(2);
      RC_DIV8: return IDX_W'(4);
      default: return IDX_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/pdiv_period_ctl.sv
// Falling-edge control: decides at each boundary the ratio and enable
// of the next period and tracks the source-cycle index inside it.
module pdiv_period_ctl
  import pdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                en_i,
  output logic                run_o,
  output ratio_code_e         code_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                gate_o
);
  logic             run_q;
  ratio_code_e      code_q;
  logic [IDX_W-1:0] idx_q;
  logic             gate_q;
  logic             at_bound;

  assign at_bound = !run_q || (idx_q == last_idx(code_q));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      code_q <= RC_DIV2;
      idx_q  <= '0;
      gate_q <= 1'b0;
    end else if (at_bound) begin
      run_q  <= en_i;
      code_q <= ratio_code_e'(code_i);
      idx_q  <= '0;
      gate_q <= en_i && (ratio_code_e'(code_i) == RC_DIV1);
    end else begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign code_o = code_q;
  assign idx_o  = idx_q;
  assign gate_o = gate_q;

  // R5
  code_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (run_q && !at_bound) |=> $stable(code_q));
  // R4
  run_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (run_q && !at_bound) |=> run_q);
  // R7
  gate_mode_chk: assert property (@(negedge clk) disable iff (!rst_n)
    gate_q |-> (run_q && code_q == RC_DIV1));
  // R1
  div1_single_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (run_q && code_q == RC_DIV1) |-> (idx_q == '0));
endmodule

// File: rtl/pdiv_phase_gen.sv
// Rising-edge level generator for the ratios of 2, 4 and 8.
module pdiv_phase_gen
  import pdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  ratio_code_e      code_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hq_o,
  output logic             rise_o
);
  logic div1;
  logic hq_q;

  assign div1 = (code_i == RC_DIV1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hq_q <= 1'b0;
    else        hq_q <= run_i && !div1 && (idx_i < high_len(code_i));
  end

  // a rising output edge coincides with this source edge
  assign rise_o = run_i && (div1 || idx_i == '0);
  assign hq_o   = hq_q;

  // R3
  parked_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !run_i |-> !hq_q);
  // R7
  no_slow_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div1 |=> !hq_q);
endmodule

// File: rtl/pdiv_test_tap.sv
// Counts output rising edges in the source domain; the MSB is the tap.
module pdiv_test_tap #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rise_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o = cnt_q[CNT_W-1];

  // R6
  tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(tap_o));
endmodule

// File: rtl/pdiv_out_stage.sv
// Final selection: gated source clock for divide by 1, registered level
// otherwise; both selects and the gate move only while the clock is low.
module pdiv_out_stage
  import pdiv_pkg::*;
(
  input  logic        clk,
  input  ratio_code_e code_i,
  input  logic        gate_i,
  input  logic        hq_i,
  output logic        out_o,
  output logic        out_n_o
);
  logic fast_path;

  assign fast_path = clk & gate_i;
  assign out_o     = (code_i == RC_DIV1) ? fast_path : hq_i;
  assign out_n_o   = ~out_o;
endmodule

// File: rtl/coded_post_divider.sv
module coded_post_divider
  import pdiv_pkg::*;
#(
  parameter int unsigned TAP_LOG2 = 2
) (
  input  logic                clk_src,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   ratio_sel,
  input  logic                out_en,
  output logic                clk_out,
  output logic                clk_out_n,
  output logic                test_div4
);
  logic             run;
  ratio_code_e      code;
  logic [IDX_W-1:0] idx;
  logic             gate;
  logic             hq;
  logic             rise;

  pdiv_period_ctl u_ctl (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .code_i (ratio_sel),
    .en_i   (out_en),
    .run_o  (run),
    .code_o (code),
    .idx_o  (idx),
    .gate_o (gate)
  );

  pdiv_phase_gen u_phase (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .run_i  (run),
    .code_i (code),
    .idx_i  (idx),
    .hq_o   (hq),
    .rise_o (rise)
  );

  pdiv_test_tap #(.CNT_W(TAP_LOG2)) u_tap (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .rise_i (rise),
    .tap_o  (test_div4)
  );

  pdiv_out_stage u_out (
    .clk     (clk_src),
    .code_i  (code),
    .gate_i  (gate),
    .hq_i    (hq),
    .out_o   (clk_out),
    .out_n_o (clk_out_n)
  );

  // R3
  off_parks_low_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
    (!run && !gate) |-> !clk_out);
endmodule

// File: tb/coded_post_divider_tb_top.sv
`timescale 1ns/1ps
module coded_post_divider_tb_top;
  logic       clk_src = 1'b0;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       out_en;
  logic       clk_out, clk_out_n, test_div4;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  bit    m_run = 0;
  int    m_ratio = 2;
  int    m_pos = 0;
  int    m_rise = 0;
  string ctx = "R9";

  always #2 clk_src = ~clk_src;

  coded_post_divider dut_i (
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .out_en    (out_en),
    .clk_out   (clk_out),
    .clk_out_n (clk_out_n),
    .test_div4 (test_div4)
  );

  function automatic int ratio_of(logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 4;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic string mode_tag();
    if (!m_run) return "R3";
    if (m_ratio == 1) return "R7";
    return "R2";
  endfunction

  task automatic chk(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0b exp=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_outs(logic exp_out);
    logic exp_tap;
    exp_tap = ((m_rise % 4) >= 2);
    chk({ctx, "/", mode_tag()}, "clk_out", clk_out, exp_out);
    chk("R8", "clk_out_n", clk_out_n, ~exp_out);
    chk("R6", "test_div4", test_div4, exp_tap);
  endtask

  // one source cycle: drive inputs for the coming falling-edge decision
  task automatic cyc(logic [1:0] code, logic en);
    logic hi;
    @(posedge clk_src); #1;
    ratio_sel = code;
    out_en    = en;
    if (m_run && (m_ratio == 1 || m_pos == 0)) m_rise++;
    if (!m_run)            hi = 1'b0;
    else if (m_ratio == 1) hi = 1'b1;
    else                   hi = (m_pos < m_ratio / 2);
    check_outs(hi);
    @(negedge clk_src); #1;
    if (!m_run)            hi = 1'b0;
    else if (m_ratio == 1) hi = 1'b0;
    else                   hi = (m_pos < m_ratio / 2);
    check_outs(hi);
    if (!m_run || m_pos == m_ratio - 1) begin
      m_run   = out_en;
      m_ratio = ratio_of(ratio_sel);
      m_pos   = 0;
    end else begin
      m_pos++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    logic [1:0]  rc;
    logic        re;
    rst_n = 1'b0;
    ratio_sel = 2'b11;
    out_en = 1'b1;
    repeat (3) @(posedge clk_src);
    #1;
    // R9 reset state
    chk("R9", "clk_out", clk_out, 1'b0);
    chk("R9", "clk_out_n", clk_out_n, 1'b1);
    chk("R9", "test_div4", test_div4, 1'b0);
    ratio_sel = 2'b00;
    out_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk_src); #1;
    check_outs(1'b0);
    m_run = out_en; m_ratio = ratio_of(ratio_sel); m_pos = 0;

    // R9/R3: parked while disabled
    ctx = "R9";
    repeat (4) cyc(2'b00, 1'b0);
    // R1: each code in turn
    ctx = "R1";
    repeat (12) cyc(2'b00, 1'b1);
    repeat (16) cyc(2'b01, 1'b1);
    repeat (32) cyc(2'b10, 1'b1);
    repeat (8)  cyc(2'b11, 1'b1);
    repeat (8)  cyc(2'b01, 1'b1);
    // R5: code changes inside a period
    ctx = "R5";
    repeat (5)  cyc(2'b10, 1'b1);
    repeat (3)  cyc(2'b00, 1'b1);
    repeat (2)  cyc(2'b11, 1'b1);
    repeat (9)  cyc(2'b10, 1'b1);
    repeat (6)  cyc(2'b01, 1'b1);
    // R4: short enable dips and a disable in a high phase
    ctx = "R4";
    repeat (10) cyc(2'b10, 1'b1);
    cyc(2'b10, 1'b0);
    repeat (11) cyc(2'b10, 1'b1);
    repeat (2)  cyc(2'b10, 1'b0);
    repeat (12) cyc(2'b10, 1'b0);
    cyc(2'b01, 1'b1);
    repeat (10) cyc(2'b01, 1'b1);
    // R7: divide by 1 with gate toggling
    ctx = "R7";
    for (int i = 0; i < 12; i++) cyc(2'b11, i[1]);
    // R2: mixed patterns
    ctx = "R2";
    lf = 16'hACE1;
    rc = 2'b00;
    re = 1'b1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'h0) rc = lf[9:8];
      if (lf[7:5] == 3'b000) re = ~re;
      cyc(rc, re);
    end
    repeat (10) cyc(2'b00, 1'b0);
    finish_run();
  end
endmodule